// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers up to 32 interrupt request lines into one processor interrupt. Each line has a fixed sense chosen at elaboration: rising edge, falling edge, active-high level or active-low level. Every input first passes through a two-flop synchronizer. A detected request is held in a status register until software acknowledges it. A per-line enable mask selects which held requests count as pending. The OR of all pending bits drives `irq_o`, and a two-bit master control gates both that output and the latching of new requests.

Software uses a small word-addressed register port. The enable mask can be written directly, or changed one bit at a time through write-one-to-set and write-one-to-clear aliases. These aliases let one handler mask or unmask a line without a read-modify-write race. A vector register returns the number of the lowest pending line, so a handler can service that line and then acknowledge it.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, status, enable and master control read 0, `irq_o` is low and the vector reads 0xFFFFFFFF.
- R2: A write to byte offset 0x08 loads the enable mask, and a read of 0x08 returns it.
- R3: A write to offset 0x10 sets each enable bit whose data bit is 1 and leaves the other enable bits unchanged.
- R4: A write to offset 0x14 clears each enable bit whose data bit is 1 and leaves the other enable bits unchanged.
- R5: A write to offset 0x0C clears each status bit (readable at 0x00) whose data bit is 1. Writing 0xFFFFFFFF clears every held request. An edge line that stays high after its acknowledge does not latch again.
- R6: Line k takes its sense code from bits [2k+1:2k] of `SENSE_CFG`: 0 means rising edge, 1 falling edge, 2 active-high level and 3 active-low level. A matching event sets status bit k. By default, line k has sense k mod 4.
- R7: The acknowledge takes priority over a request in the same cycle. A level line that is still asserted latches again on the cycle after the acknowledge.
- R8: Offset 0x04 reads pending, which is status AND enable.
- R9: The master control at offset 0x1C has two bits. Bit 0 gates `irq_o`. Bit 1 allows new requests to latch into status.
- R10: `irq_o` is high exactly when some pending bit is set and master bit 0 is 1.
- R11: Offset 0x18 reads the index of the lowest-numbered pending line, or 0xFFFFFFFF when nothing is pending.
- R12: A change on `irq_i` driven before rising edge e first shows in status after edge e+2. Edge lines compare the synchronized value with its value one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | N_LINES (32) | Raw interrupt request lines |
| bus_req_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | Write when 1, read when 0 |
| bus_addr_i | input | 5 | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| irq_o | output | 1 | Interrupt to the processor |

## Verification
The hardest case to reach from the ports is an acknowledge that lands in the same cycle as a live request on a level line. The acknowledge must win for exactly one cycle, and the request must return on the next one. The bench holds an active-high line asserted and issues the acknowledge write. It reads status on the falling edge right after the write's clock edge, where the bit must be clear, and again one cycle later, where the bit must be set. The two-flop latency is pinned in a similar way: the bench reads status after the second and after the third rising edge following an input change.

// File: rtl/vic_pkg.sv
package vic_pkg;
  typedef enum logic [1:0] {
    SENSE_RISE = 2'd0,
    SENSE_FALL = 2'd1,
    SENSE_HIGH = 2'd2,
    SENSE_LOW  = 2'd3
  } sense_e;

  localparam int unsigned BUS_DW = 32;
  localparam int unsigned BUS_AW = 5;

  // word index = byte offset / 4
  localparam logic [2:0] REG_STATUS = 3'd0;
  localparam logic [2:0] REG_PEND   = 3'd1;
  localparam logic [2:0] REG_ENABLE = 3'd2;
  localparam logic [2:0] REG_ACK    = 3'd3;
  localparam logic [2:0] REG_SET_EN = 3'd4;
  localparam logic [2:0] REG_CLR_EN = 3'd5;
  localparam logic [2:0] REG_VECTOR = 3'd6;
  localparam logic [2:0] REG_MASTER = 3'd7;
endpackage

// File: rtl/vic_detect.sv
module vic_detect #(
  parameter int unsigned           N_LINES   = 32,
  parameter logic [2*N_LINES-1:0]  SENSE_CFG = {(N_LINES/4){8'hE4}}
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] irq_i,
  output logic [N_LINES-1:0] req_o
);
  import vic_pkg::*;

  logic [N_LINES-1:0] sync0_q, sync1_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync0_q <= '0;
      sync1_q <= '0;
      prev_q  <= '0;
    end else begin
      sync0_q <= irq_i;
      sync1_q <= sync0_q;
      prev_q  <= sync1_q;
    end
  end

  for (genvar k = 0; k < N_LINES; k++) begin : g_line
    localparam sense_e SENSE = sense_e'(SENSE_CFG[2*k +: 2]);
    if (SENSE == SENSE_RISE) begin : g_rise
      assign req_o[k] = sync1_q[k] & ~prev_q[k];
    end else if (SENSE == SENSE_FALL) begin : g_fall
      assign req_o[k] = ~sync1_q[k] & prev_q[k];
    end else if (SENSE == SENSE_HIGH) begin : g_high
      assign req_o[k] = sync1_q[k];
    end else begin : g_low
      assign req_o[k] = ~sync1_q[k];
    end
  end
endmodule

// File: rtl/vic_regs.sv
module vic_regs #(
  parameter int unsigned N_LINES = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [2:0]                 wr_idx_i,
  input  logic [vic_pkg::BUS_DW-1:0] wdata_i,
  input  logic [N_LINES-1:0]         req_i,
  output logic [N_LINES-1:0]         status_o,
  output logic [N_LINES-1:0]         enable_o,
  output logic [1:0]                 master_o
);
  import vic_pkg::*;

  logic [N_LINES-1:0] status_q, enable_q, ack_mask, wbits, latch_req;
  logic [1:0]         master_q;

  assign wbits     = wdata_i[N_LINES-1:0];
  assign ack_mask  = (wr_en_i && wr_idx_i == REG_ACK) ? wbits : '0;
  assign latch_req = master_q[1] ? req_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
    end else begin
      // acknowledge wins over a same-cycle request
      status_q <= (status_q | latch_req) & ~ack_mask;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enable_q <= '0;
      master_q <= '0;
    end else if (wr_en_i) begin
      case (wr_idx_i)
        REG_ENABLE: enable_q <= wbits;
        REG_SET_EN: enable_q <= enable_q | wbits;
        REG_CLR_EN: enable_q <= enable_q & ~wbits;
        REG_MASTER: master_q <= wdata_i[1:0];
        default: ;
      endcase
    end
  end

  assign status_o = status_q;
  assign enable_o = enable_q;
  assign master_o = master_q;

  // R3
  set_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_idx_i == REG_SET_EN) |=>
      ((enable_q & $past(wbits)) == $past(wbits)));

  // R4
  clr_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_idx_i == REG_CLR_EN) |=> ((enable_q & $past(wbits)) == '0));

  // R5
  ack_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_idx_i == REG_ACK) |=> ((status_q & $past(wbits)) == '0));

  // R9
  latch_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_q[1] |=> ((status_q & ~$past(status_q)) == '0));
endmodule

// File: rtl/vic_prio.sv
module vic_prio #(
  parameter int unsigned N_LINES = 32,
  localparam int unsigned IDX_W  = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input  logic [N_LINES-1:0] pending_i,
  output logic               found_o,
  output logic [IDX_W-1:0]   idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    // scan downward so the lowest set bit is assigned last
    for (int k = N_LINES - 1; k >= 0; k--) begin
      if (pending_i[k]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(k);
      end
    end
  end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
  parameter int unsigned          N_LINES   = 32,
  parameter logic [2*N_LINES-1:0] SENSE_CFG = {(N_LINES/4){8'hE4}}
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [N_LINES-1:0]         irq_i,
  input  logic                       bus_req_i,
  input  logic                       bus_we_i,
  input  logic [vic_pkg::BUS_AW-1:0] bus_addr_i,
  input  logic [vic_pkg::BUS_DW-1:0] bus_wdata_i,
  output logic [vic_pkg::BUS_DW-1:0] bus_rdata_o,
  output logic                       irq_o
);
  import vic_pkg::*;

  localparam int unsigned IDX_W = (N_LINES > 1) ? $clog2(N_LINES) : 1;

  logic [N_LINES-1:0] req, status, enable, pending;
  logic [1:0]         master;
  logic [2:0]         reg_idx;
  logic               wr_en, found;
  logic [IDX_W-1:0]   idx;
  logic [BUS_DW-1:0]  vector;
  logic               unused_addr_lsb;

  assign reg_idx         = bus_addr_i[4:2];
  assign unused_addr_lsb = ^bus_addr_i[1:0];
  assign wr_en           = bus_req_i & bus_we_i;

  vic_detect #(.N_LINES(N_LINES), .SENSE_CFG(SENSE_CFG)) u_detect (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .irq_i  (irq_i),
    .req_o  (req)
  );

  vic_regs #(.N_LINES(N_LINES)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en),
    .wr_idx_i (reg_idx),
    .wdata_i  (bus_wdata_i),
    .req_i    (req),
    .status_o (status),
    .enable_o (enable),
    .master_o (master)
  );

  assign pending = status & enable;

  vic_prio #(.N_LINES(N_LINES)) u_prio (
    .pending_i (pending),
    .found_o   (found),
    .idx_o     (idx)
  );

  assign vector = found ? BUS_DW'(idx) : '1;
  assign irq_o  = master[0] & found;

  always_comb begin
    case (reg_idx)
      REG_STATUS: bus_rdata_o = BUS_DW'(status);
      REG_PEND:   bus_rdata_o = BUS_DW'(pending);
      REG_ENABLE: bus_rdata_o = BUS_DW'(enable);
      REG_VECTOR: bus_rdata_o = vector;
      REG_MASTER: bus_rdata_o = BUS_DW'(master);
      default:    bus_rdata_o = '0;
    endcase
  end

  // R11
  vec_none_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending == '0) |-> (vector == '1));

  // R11
  vec_lowest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending != '0) |-> (pending[idx] &&
      ((pending & ((N_LINES'(1) << idx) - N_LINES'(1))) == '0)));

  // R10
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (master[0] && (status & enable) != '0));
endmodule

// File: tb/vec_irq_ctrl_test.sv
module vec_irq_ctrl_test;
  localparam int CLK_PERIOD = 10;

  localparam logic [4:0] A_STATUS = 5'h00;
  localparam logic [4:0] A_PEND   = 5'h04;
  localparam logic [4:0] A_ENABLE = 5'h08;
  localparam logic [4:0] A_ACK    = 5'h0C;
  localparam logic [4:0] A_SET    = 5'h10;
  localparam logic [4:0] A_CLR    = 5'h14;
  localparam logic [4:0] A_VEC    = 5'h18;
  localparam logic [4:0] A_MASTER = 5'h1C;
  localparam logic [31:0] IDLE    = 32'h8888_8888; // active-low lines held high

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_in = IDLE;
  logic        req = 1'b0, we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_irq_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq_in),
    .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic expect_reg(input string tag, input logic [4:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(tag, v, exp);
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    expect_reg("R1 status", A_STATUS, 32'h0);
    expect_reg("R1 enable", A_ENABLE, 32'h0);
    expect_reg("R1 master", A_MASTER, 32'h0);
    expect_reg("R1 vector", A_VEC, 32'hFFFF_FFFF);
    check("R1 irq_o", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_enable;
    wr(A_ENABLE, 32'h0000_00F0);
    expect_reg("R2 enable write", A_ENABLE, 32'h0000_00F0);
    wr(A_SET, 32'h0000_0F00);
    expect_reg("R3 set-enable", A_ENABLE, 32'h0000_0FF0);
    wr(A_CLR, 32'h0000_0030);
    expect_reg("R4 clear-enable", A_ENABLE, 32'h0000_0FC0);
    wr(A_SET, 32'hFFFF_FFFF);
  endtask

  task automatic t_rise_sync;
    wr(A_MASTER, 32'h3);
    settle(4);
    expect_reg("R6 idle lines latch nothing", A_STATUS, 32'h0);
    @(negedge clk);
    irq_in[0] = 1'b1;
    @(negedge clk); @(negedge clk);
    expect_reg("R12 not yet after two edges", A_STATUS, 32'h0);
    @(negedge clk);
    expect_reg("R12 latched after third edge", A_STATUS, 32'h1);
    check("R10 irq_o high", {31'b0, irq}, 32'h1);
    expect_reg("R11 vector line 0", A_VEC, 32'h0);
    wr(A_ACK, 32'h1);
    settle(3);
    expect_reg("R5 edge line held high stays clear", A_STATUS, 32'h0);
    check("R10 irq_o low", {31'b0, irq}, 32'h0);
    irq_in[0] = 1'b0;
    settle(3);
  endtask

  task automatic t_fall;
    irq_in[1] = 1'b1;
    settle(4);
    expect_reg("R6 falling line ignores rise", A_STATUS, 32'h0);
    irq_in[1] = 1'b0;
    settle(4);
    expect_reg("R6 falling line latches", A_STATUS, 32'h2);
    wr(A_ACK, 32'h2);
  endtask

  task automatic t_level;
    irq_in[2] = 1'b1;
    settle(4);
    expect_reg("R6 high level latches", A_STATUS, 32'h4);
    wr(A_ACK, 32'h4);
    expect_reg("R7 ack wins same cycle", A_STATUS, 32'h0);
    @(negedge clk);
    expect_reg("R7 level relatches next cycle", A_STATUS, 32'h4);
    irq_in[2] = 1'b0;
    settle(3);
    wr(A_ACK, 32'h4);
    settle(2);
    expect_reg("R7 released level stays clear", A_STATUS, 32'h0);
  endtask

  task automatic t_low;
    irq_in[3] = 1'b0;
    settle(4);
    expect_reg("R6 low level latches", A_STATUS, 32'h8);
    irq_in[3] = 1'b1;
    settle(3);
    wr(A_ACK, 32'h8);
    settle(2);
    expect_reg("R6 low level cleared", A_STATUS, 32'h0);
  endtask

  task automatic t_prio;
    irq_in[8] = 1'b1; irq_in[4] = 1'b1;
    settle(4);
    irq_in[8] = 1'b0; irq_in[4] = 1'b0;
    expect_reg("R11 lowest of 4 and 8", A_VEC, 32'd4);
    wr(A_ACK, 32'h10);
    expect_reg("R11 next lowest", A_VEC, 32'd8);
    expect_reg("R8 pending", A_PEND, 32'h100);
  endtask

  task automatic t_pending;
    wr(A_CLR, 32'h100);
    expect_reg("R8 masked pending", A_PEND, 32'h0);
    expect_reg("R8 status kept", A_STATUS, 32'h100);
    check("R10 masked irq_o", {31'b0, irq}, 32'h0);
    expect_reg("R11 none pending", A_VEC, 32'hFFFF_FFFF);
    wr(A_SET, 32'h100);
  endtask

  task automatic t_master;
    wr(A_MASTER, 32'h2);
    check("R9 bit0 gates irq_o", {31'b0, irq}, 32'h0);
    wr(A_MASTER, 32'h3);
    check("R9 irq_o restored", {31'b0, irq}, 32'h1);
    wr(A_ACK, 32'hFFFF_FFFF);
    expect_reg("R5 ack all", A_STATUS, 32'h0);
    wr(A_MASTER, 32'h1);
    irq_in[12] = 1'b1;
    settle(5);
    expect_reg("R9 bit1 blocks latching", A_STATUS, 32'h0);
    irq_in[12] = 1'b0;
    wr(A_MASTER, 32'h3);
    settle(4);
    expect_reg("R9 no late latch", A_STATUS, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable();
    t_rise_sync();
    t_fall();
    t_level();
    t_low();
    t_prio();
    t_pending();
    t_master();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule